// File: doc/BRIEF.md
# External Static Memory Bridge

This block connects an internal 32-bit request port to an external asynchronous static memory bus. A small bank of 32-bit configuration words sits behind a separate peripheral register port. Each word describes one chip-select region: where it lives, how large it is, whether it is on, how wide its devices are, how many wait states it needs and whether reads use the fast timing. When an internal request arrives, the block chooses the region that owns the address. It then runs one or more external bus cycles, driving chip select, address, read and write strobes, byte selects and write data. When the last cycle is done it answers with a one-clock acknowledge that carries the assembled read data.

A region can hold a single byte-wide device, a single halfword device with lane selects, or two byte-wide devices that act as one halfword device, each with its own write strobe. A word access to a halfword region takes two external cycles with the lower halfword first. A word access to a byte region takes four cycles at ascending byte addresses. An address that no enabled region claims is answered with an error and leaves every chip select idle.

Top module: `xsm_bridge`

## Requirements
- R1: After reset every configuration word reads as zero, all chip selects, strobes and byte selects are high (inactive), the data output enable is low, and `ack`/`err` are low.
- R2: Writing the configuration port with `psel`=1 and `pwrite`=1 stores `pwdata` in word `paddr[PAW-1:2]` on that clock. `prdata` always shows all 32 bits of the word selected by `paddr`.
- R3: Word fields: bits 31:20 base (address bits 31:20), bits 17:16 size code s (the region spans 2^s MiB, so base bits below s are ignored), bit 8 enable. The lowest-numbered matching enabled region wins. Exactly one `cs_n` bit is low, and only during that access's external cycles.
- R4: A request that matches no enabled region drives `ack`=1 and `err`=1 for one clock, on the clock after it is accepted. No chip select or strobe goes low.
- R5: Bits 5:4 select width: 00 byte device, 01 halfword device, 10 paired byte devices, 11 behaves as 01. `sz` (0 byte, 1 halfword, 2 word) on a halfword-wide region gives one cycle for byte or halfword and two cycles for a word, at `addr` then `addr`+2. On a byte region it gives 1, 2 or 4 cycles at `addr`, `addr`+1, and so on. Byte-region data uses `xdin/xdout[7:0]`.
- R6: A halfword-device region drives `bs_n` low on the lanes in use for the whole external cycle: bit 0 for even bytes, bit 1 for odd bytes, both for halfword and word accesses. Its only write strobe is `we_n[0]`, and `we_n[1]` stays high.
- R7: A paired-byte region keeps `bs_n` high and lowers `we_n[0]` and `we_n[1]` only for the byte lanes being written.
- R8: Bits 2:0 give a wait count w (0..7). Each external cycle is one setup clock (chip select and address valid, strobes high) followed by 1+w clocks with the strobe low.
- R9: Bit 3 set makes each read cycle skip its setup clock, so the read strobe is low from the cycle's first clock and a zero-wait read cycle lasts one clock. Writes keep their setup clock.
- R10: `xdoe` is high exactly while a write strobe is low. During that time `xdout` carries the written lanes and zeros elsewhere.
- R11: `ack` rises for one clock on the clock after the last external cycle's strobe phase. For a read, `rdata` then holds each fetched byte in its own address lane and zero in lanes not fetched.
- R12: An access takes its region's configuration as it stood when it was accepted. A configuration write on that same clock affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until `ack` |
| we | input | 1 | 1 write, 0 read |
| sz | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr | input | 32 | Byte address, naturally aligned |
| wdata | input | 32 | Write data in byte lanes |
| ack | output | 1 | One-clock completion pulse |
| err | output | 1 | With `ack`: no region matched |
| rdata | output | 32 | Read data, valid with `ack` |
| psel | input | 1 | Configuration port select |
| pwrite | input | 1 | Configuration write |
| paddr | input | PAW | Configuration byte address |
| pwdata | input | 32 | Configuration write data |
| prdata | output | 32 | Configuration read data |
| cs_n | output | NREG | Chip selects, active low |
| xaddr | output | XAW | External byte address |
| xdout | output | 16 | External write data |
| xdoe | output | 1 | Data output enable |
| xdin | input | 16 | External read data |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 2 | Write strobes, active low |
| bs_n | output | 2 | Byte-lane selects, active low |

## Verification
A configuration write and the acceptance of a request can land on the same clock edge. The access must then keep the region's previous settings, while the next access picks up the new ones. The bench provokes this by raising `psel`/`pwrite` and `req` together, aimed at the region being reprogrammed. It builds its expected cycle list from the old settings and then from the new ones, and compares strobes, lanes, addresses and data on every clock.

// File: rtl/xsm_pkg.sv
package xsm_pkg;

  typedef enum logic [1:0] {WM_BYTE = 2'b00, WM_HALF = 2'b01, WM_PAIR = 2'b10, WM_HALF2 = 2'b11} wmode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STRB, ST_RESP} state_e;

  typedef struct packed {
    logic [11:0] base;
    logic [1:0]  size;
    logic        en;
    wmode_e      wm;
    logic        early;
    logic [2:0]  waits;
  } cfg_t;

  function automatic cfg_t unpack_cfg(logic [31:0] w);
    cfg_t c;
    c.base  = w[31:20];
    c.size  = w[17:16];
    c.en    = w[8];
    c.wm    = wmode_e'(w[5:4]);
    c.early = w[3];
    c.waits = w[2:0];
    return c;
  endfunction

  function automatic logic region_hit(cfg_t c, logic [11:0] top_bits);
    logic [11:0] keep;
    keep = ~((12'd1 << c.size) - 12'd1);
    return c.en && ((top_bits & keep) == (c.base & keep));
  endfunction

  // Index of the final external cycle for a given device width and size
  function automatic logic [1:0] last_idx(logic wide, logic [1:0] sz);
    case (sz)
      2'd0:    return 2'd0;
      2'd1:    return wide ? 2'd0 : 2'd1;
      default: return wide ? 2'd1 : 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] lane_sel(logic wide, logic [1:0] sz, logic a0);
    if (!wide)      return 2'b01;
    if (sz != 2'd0) return 2'b11;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [15:0] pack_out(logic wide, logic [1:0] ea, logic [1:0] le, logic [31:0] wd);
    logic [1:0]  b;
    logic [1:0]  p;
    logic [15:0] r;
    b = wide ? {ea[1], 1'b0} : ea;
    r = '0;
    for (int i = 0; i < 2; i++) begin
      p = b + 2'(i);
      if (le[i]) r[8*i +: 8] = wd[8*p +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] merge_in(logic [31:0] cur, logic wide, logic [1:0] ea,
                                           logic [1:0] le, logic [15:0] din);
    logic [1:0]  b;
    logic [1:0]  p;
    logic [31:0] r;
    b = wide ? {ea[1], 1'b0} : ea;
    r = cur;
    for (int i = 0; i < 2; i++) begin
      p = b + 2'(i);
      if (le[i]) r[8*p +: 8] = din[8*i +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/xsm_cfg_regs.sv
module xsm_cfg_regs #(
  parameter int NREG = 4,
  parameter int PAW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PAW-1:0]         waddr,
  input  logic [31:0]            wdata,
  output logic [NREG-1:0][31:0]  regs
);
  localparam int IW = $clog2(NREG);

  logic [IW-1:0] widx;
  assign widx = waddr[IW+1:2];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs[g] <= '0;
      else if (wr_en && widx == IW'(g))      regs[g] <= wdata;
    end
  end
endmodule

// File: rtl/xsm_decode.sv
module xsm_decode
  import xsm_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [NREG-1:0][31:0] regs,
  input  logic [11:0]           top_bits,
  output logic                  hit,
  output logic [$clog2(NREG)-1:0] idx,
  output cfg_t                  sel
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0] match;
  cfg_t            cfgs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign cfgs[g]  = unpack_cfg(regs[g]);
    assign match[g] = region_hit(cfgs[g], top_bits);
  end

  // Lowest-numbered region has priority
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (match[i]) idx = IW'(i);
  end

  assign hit = |match;
  assign sel = cfgs[idx];
endmodule

// File: rtl/xsm_seq.sv
module xsm_seq
  import xsm_pkg::*;
#(
  parameter int NREG = 4,
  parameter int XAW  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [1:0]               sz,
  input  logic [XAW-1:0]           a_in,
  input  logic [31:0]              wdata,
  input  logic                     hit,
  input  logic [$clog2(NREG)-1:0]  idx,
  input  cfg_t                     sel,
  input  logic [15:0]              xdin,
  output logic                     ack,
  output logic                     err,
  output logic [31:0]              rdata,
  output logic [NREG-1:0]          cs_n,
  output logic [XAW-1:0]           xaddr,
  output logic [15:0]              xdout,
  output logic                     xdoe,
  output logic                     rd_n,
  output logic [1:0]               we_n,
  output logic [1:0]               bs_n,
  output logic                     ev_accept,
  output logic                     ev_cyc_end
);
  localparam int IW = $clog2(NREG);

  state_e         st;
  logic [1:0]     k, last_q;
  logic [2:0]     cnt, ws_q;
  logic [XAW-1:0] a_q;
  logic [31:0]    wd_q;
  logic [1:0]     sz_q;
  logic [IW-1:0]  idx_q;
  logic           we_q, wide_q, pair_q, early_q, err_q;

  logic [1:0] offs, ea_lo, le;
  logic       in_cyc, strb, wr;

  assign offs   = wide_q ? {k[0], 1'b0} : k;
  assign ea_lo  = a_q[1:0] + offs;
  assign le     = lane_sel(wide_q, sz_q, a_q[0]);
  assign in_cyc = (st == ST_SETUP) || (st == ST_STRB);
  assign strb   = (st == ST_STRB);
  assign wr     = strb && we_q;

  assign ev_accept  = (st == ST_IDLE) && req;
  assign ev_cyc_end = strb && (cnt == 3'd0);

  assign cs_n  = in_cyc ? ~(NREG'(1) << idx_q) : '1;
  assign xaddr = {a_q[XAW-1:2], ea_lo};
  assign rd_n  = ~(strb && !we_q);
  assign we_n  = pair_q ? ~(le & {2{wr}}) : {1'b1, ~wr};
  assign bs_n  = (in_cyc && wide_q && !pair_q) ? ~le : 2'b11;
  assign xdoe  = wr;
  assign xdout = pack_out(wide_q, ea_lo, le, wd_q);
  assign ack   = (st == ST_RESP);
  assign err   = ack && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; k <= '0; last_q <= '0; cnt <= '0; ws_q <= '0;
      a_q <= '0; wd_q <= '0; sz_q <= '0; idx_q <= '0; rdata <= '0;
      we_q <= 1'b0; wide_q <= 1'b0; pair_q <= 1'b0; early_q <= 1'b0; err_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req) begin
          a_q     <= a_in;
          wd_q    <= wdata;
          sz_q    <= sz;
          we_q    <= we;
          idx_q   <= idx;
          wide_q  <= (sel.wm != WM_BYTE);
          pair_q  <= (sel.wm == WM_PAIR);
          early_q <= sel.early;
          ws_q    <= sel.waits;
          last_q  <= last_idx(sel.wm != WM_BYTE, sz);
          k       <= '0;
          rdata   <= '0;
          err_q   <= !hit;
          cnt     <= sel.waits;
          if (!hit)                     st <= ST_RESP;
          else if (sel.early && !we)    st <= ST_STRB;
          else                          st <= ST_SETUP;
        end
        ST_SETUP: begin
          st  <= ST_STRB;
          cnt <= ws_q;
        end
        ST_STRB: begin
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else begin
            if (!we_q) rdata <= merge_in(rdata, wide_q, ea_lo, le, xdin);
            if (k == last_q) st <= ST_RESP;
            else begin
              k <= k + 2'd1;
              if (early_q && !we_q) begin
                st  <= ST_STRB;
                cnt <= ws_q;
              end else st <= ST_SETUP;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xsm_bridge.sv
module xsm_bridge
  import xsm_pkg::*;
#(
  parameter int NREG = 4,
  parameter int XAW  = 24,
  parameter int PAW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        sz,
  input  logic [31:0]       addr,
  input  logic [31:0]       wdata,
  output logic              ack,
  output logic              err,
  output logic [31:0]       rdata,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [PAW-1:0]    paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [NREG-1:0]   cs_n,
  output logic [XAW-1:0]    xaddr,
  output logic [15:0]       xdout,
  output logic              xdoe,
  input  logic [15:0]       xdin,
  output logic              rd_n,
  output logic [1:0]        we_n,
  output logic [1:0]        bs_n
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0][31:0] regs;
  logic                  hit;
  logic [IW-1:0]         idx;
  cfg_t                  sel;
  logic                  ev_accept, ev_cyc_end;

  xsm_cfg_regs #(.NREG(NREG), .PAW(PAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(psel && pwrite),
    .waddr(paddr), .wdata(pwdata), .regs(regs)
  );

  assign prdata = regs[paddr[IW+1:2]];

  xsm_decode #(.NREG(NREG)) u_dec (
    .regs(regs), .top_bits(addr[31:20]), .hit(hit), .idx(idx), .sel(sel)
  );

  xsm_seq #(.NREG(NREG), .XAW(XAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .sz(sz),
    .a_in(addr[XAW-1:0]), .wdata(wdata), .hit(hit), .idx(idx), .sel(sel),
    .xdin(xdin), .ack(ack), .err(err), .rdata(rdata), .cs_n(cs_n),
    .xaddr(xaddr), .xdout(xdout), .xdoe(xdoe), .rd_n(rd_n), .we_n(we_n),
    .bs_n(bs_n), .ev_accept(ev_accept), .ev_cyc_end(ev_cyc_end)
  );
endmodule

// File: rtl/xsm_bridge_chk.sv
module xsm_bridge_chk #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            err,
  input logic [NREG-1:0] cs_n,
  input logic            rd_n,
  input logic [1:0]      we_n,
  input logic [1:0]      bs_n,
  input logic            xdoe,
  input logic            ev_accept,
  input logic            ev_cyc_end
);
  localparam logic [NREG-1:0] NONE = '1;

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_strobe_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || we_n != 2'b11) |-> cs_n != NONE);

  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (cs_n != NONE) || (ack && err));

  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err) |-> (cs_n == NONE) && ($past(cs_n) == NONE));

  assert_half_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_n != 2'b11) |-> we_n[1]);

  assert_no_rd_and_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && we_n != 2'b11));

  assert_oe_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xdoe == (we_n != 2'b11));

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_after_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err) |-> $past(ev_cyc_end));
endmodule

bind xsm_bridge xsm_bridge_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .err(err), .cs_n(cs_n), .rd_n(rd_n),
  .we_n(we_n), .bs_n(bs_n), .xdoe(xdoe), .ev_accept(ev_accept), .ev_cyc_end(ev_cyc_end)
);

// File: tb/xsm_bridge_test.sv
module xsm_bridge_test;
  localparam int CLK_NS = 10;
  localparam int NREG = 4;
  localparam int XAW = 24;
  localparam int PAW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] sz = '0;
  logic [31:0] addr = '0, wdata = '0, pwdata = '0;
  logic psel = 1'b0, pwrite = 1'b0;
  logic [PAW-1:0] paddr = '0;
  logic ack, err, xdoe, rd_n;
  logic [31:0] rdata, prdata;
  logic [NREG-1:0] cs_n;
  logic [XAW-1:0] xaddr;
  logic [15:0] xdout, xdin;
  logic [1:0] we_n, bs_n;

  always #(CLK_NS/2) clk = ~clk;

  xsm_bridge #(.NREG(NREG), .XAW(XAW), .PAW(PAW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .sz(sz), .addr(addr), .wdata(wdata),
    .ack(ack), .err(err), .rdata(rdata), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .cs_n(cs_n), .xaddr(xaddr), .xdout(xdout),
    .xdoe(xdoe), .xdin(xdin), .rd_n(rd_n), .we_n(we_n), .bs_n(bs_n)
  );

  function automatic logic [7:0] pat(logic [XAW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  assign xdin = {pat(xaddr | 24'd1), pat(xaddr)};

  typedef struct {
    logic [NREG-1:0] cs_n; logic rd_n; logic [1:0] we_n; logic [1:0] bs_n;
    logic xdoe; logic ack; logic err; logic [XAW-1:0] xaddr; logic [15:0] xdout;
    logic [31:0] rdata; logic chk_rd; string tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] mirror [NREG];
  int nchk = 0, nerr = 0;
  bit run = 0, done = 0;

  function automatic exp_t idle_t(string tag);
    exp_t e;
    e.cs_n = '1; e.rd_n = 1; e.we_n = 2'b11; e.bs_n = 2'b11; e.xdoe = 0; e.ack = 0;
    e.err = 0; e.xaddr = '0; e.xdout = '0; e.rdata = '0; e.chk_rd = 0; e.tag = tag;
    return e;
  endfunction

  // Per-clock comparison against the expected cycle list
  always @(negedge clk) if (run) begin
    exp_t e;
    bit bad;
    e = (q.size() != 0) ? q.pop_front() : idle_t("R3");
    bad = (cs_n !== e.cs_n) || (rd_n !== e.rd_n) || (we_n !== e.we_n) || (bs_n !== e.bs_n)
       || (xdoe !== e.xdoe) || (ack !== e.ack) || (err !== e.err);
    if (e.cs_n != '1 && xaddr !== e.xaddr) bad = 1;
    if (e.xdoe && xdout !== e.xdout) bad = 1;
    if (e.chk_rd && rdata !== e.rdata) bad = 1;
    nchk++;
    if (bad) begin
      nerr++;
      $display("FAIL %s t=%0t act cs=%b rd=%b we=%b bs=%b oe=%b ack=%b err=%b a=%h d=%h r=%h exp cs=%b rd=%b we=%b bs=%b oe=%b ack=%b err=%b a=%h d=%h r=%h",
        e.tag, $time, cs_n, rd_n, we_n, bs_n, xdoe, ack, err, xaddr, xdout, rdata,
        e.cs_n, e.rd_n, e.we_n, e.bs_n, e.xdoe, e.ack, e.err, e.xaddr, e.xdout, e.rdata);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Build the expected external cycles from the bench's own view of the settings
  task automatic plan(string tag, logic w, logic [1:0] s, logic [31:0] a, logic [31:0] d);
    int hit_i = -1;
    for (int i = 0; i < NREG; i++) begin
      logic [11:0] m;
      m = 12'hFFF << mirror[i][17:16];
      if (hit_i < 0 && mirror[i][8] && (((a[31:20] ^ mirror[i][31:20]) & m) == 12'h0)) hit_i = i;
    end
    if (hit_i < 0) begin
      exp_t e;
      e = idle_t(tag); e.ack = 1; e.err = 1;
      q.push_back(e);
    end else begin
      logic [31:0] c;
      bit wide, pair, early;
      int nbytes, ncyc, step, ws;
      logic [1:0] le;
      logic [31:0] rexp;
      exp_t e;
      c = mirror[hit_i];
      wide = (c[5:4] != 2'b00); pair = (c[5:4] == 2'b10); early = c[3]; ws = int'(c[2:0]);
      nbytes = 1 << s;
      step = wide ? 2 : 1;
      ncyc = wide ? ((nbytes == 1) ? 1 : nbytes / 2) : nbytes;
      le = !wide ? 2'b01 : (nbytes >= 2 ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
      for (int kk = 0; kk < ncyc; kk++) begin
        logic [XAW-1:0] ea;
        int lb;
        ea = a[XAW-1:0] + XAW'(kk * step);
        e = idle_t(tag);
        e.cs_n = ~(NREG'(1) << hit_i); e.xaddr = ea;
        e.bs_n = (wide && !pair) ? ~le : 2'b11;
        if (!(early && !w)) q.push_back(e);
        lb = wide ? int'(ea[1:0] & 2'b10) : int'(ea[1:0]);
        e.rd_n = w;
        e.we_n = !w ? 2'b11 : (pair ? ~le : 2'b10);
        e.xdoe = w;
        e.xdout = '0;
        for (int i = 0; i < 2; i++) if (le[i]) e.xdout[8*i +: 8] = d[8*(lb+i) +: 8];
        for (int t = 0; t <= ws; t++) q.push_back(e);
      end
      rexp = '0;
      for (int j = 0; j < nbytes; j++) rexp[8*((int'(a[1:0]) + j) % 4) +: 8] = pat(a[XAW-1:0] + XAW'(j));
      e = idle_t(tag); e.ack = 1; e.rdata = rexp; e.chk_rd = !w;
      q.push_back(e);
    end
  endtask

  task automatic wait_drain();
    forever begin
      @(negedge clk); #1;
      if (q.size() == 0) break;
    end
    req = 0;
  endtask

  task automatic access(string tag, logic w, logic [1:0] s, logic [31:0] a, logic [31:0] d);
    @(negedge clk); #1;
    plan(tag, w, s, a, d);
    we = w; sz = s; addr = a; wdata = d; req = 1;
    wait_drain();
  endtask

  task automatic cfgw(int i, logic [31:0] v);
    @(negedge clk); #1;
    psel = 1; pwrite = 1; paddr = PAW'(i * 4); pwdata = v;
    @(negedge clk); #1;
    psel = 0; pwrite = 0;
    mirror[i] = v;
  endtask

  task automatic cfgr(string tag, int i);
    @(negedge clk); #1;
    paddr = PAW'(i * 4);
    #1;
    check(tag, prdata, mirror[i]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    run = 1;
    // R1: reset state at the ports
    @(negedge clk); #1;
    check("R1", {27'd0, &cs_n, rd_n, &we_n, &bs_n, xdoe}, {27'd0, 4'b1111, 1'b0});
    check("R1", {30'd0, ack, err}, 32'd0);
    for (int i = 0; i < NREG; i++) cfgr("R1", i);

    // Region setup: byte, halfword (2 MiB), paired bytes, halfword with fast reads
    cfgw(0, 32'h0000_0100);                 // base 0x000, byte wide, 0 waits
    cfgw(1, 32'h1001_0112);                 // base 0x100, size 1, half, 2 waits
    cfgw(2, 32'h2000_0121);                 // base 0x200, pair, 1 wait
    cfgw(3, 32'h3000_4118);                 // base 0x300, half, fast read, 0 waits (bit 14 junk)
    for (int i = 0; i < NREG; i++) cfgr("R2", i);

    access("R5", 0, 2'd2, 32'h0000_0010, '0);           // byte device word read: 4 cycles
    access("R5", 1, 2'd2, 32'h0000_0020, 32'hA1B2_C3D4);
    access("R10", 1, 2'd0, 32'h0000_0013, 32'h7700_0000);
    access("R8", 0, 2'd2, 32'h1000_0040, '0);           // half, 2 waits, 2 cycles
    access("R6", 1, 2'd2, 32'h1000_0044, 32'h1234_5678);
    access("R6", 1, 2'd0, 32'h1010_0005, 32'h0000_EE00); // size 1 region reaches 0x101
    access("R11", 0, 2'd1, 32'h1000_0102, '0);
    access("R7", 1, 2'd2, 32'h2000_0008, 32'hCAFE_F00D);
    access("R7", 1, 2'd0, 32'h2000_0003, 32'h9900_0000);
    access("R11", 0, 2'd0, 32'h2000_0001, '0);
    access("R9", 0, 2'd2, 32'h3000_0010, '0);           // fast read, 1 clock per cycle
    access("R9", 1, 2'd1, 32'h3000_0012, 32'h0000_BEEF);
    cfgw(3, 32'h3000_010A);                             // fast read with 2 waits
    access("R9", 0, 2'd1, 32'h3000_0006, '0);
    access("R4", 0, 2'd2, 32'h4000_0000, '0);           // no region
    cfgw(3, 32'h3000_0011);                             // region 3 disabled
    access("R4", 1, 2'd2, 32'h3000_0000, 32'h1);
    cfgw(1, 32'h0000_0111);                             // overlaps region 0
    access("R3", 0, 2'd0, 32'h0000_0007, '0);           // region 0 wins
    cfgw(3, 32'h3000_0135);                             // width code 11 acts as halfword, 5 waits
    access("R5", 1, 2'd2, 32'h3000_0000, 32'h0BAD_F00D);

    // R12: configuration write and request on the same clock
    @(negedge clk); #1;
    plan("R12", 0, 2'd2, 32'h2000_0010, '0);
    psel = 1; pwrite = 1; paddr = PAW'(2 * 4); pwdata = 32'h2000_0100;
    we = 0; sz = 2'd2; addr = 32'h2000_0010; req = 1;
    @(negedge clk); #1;
    psel = 0; pwrite = 0;
    mirror[2] = 32'h2000_0100;
    wait_drain();
    access("R12", 0, 2'd2, 32'h2000_0010, '0);          // now a byte device
    cfgr("R12", 2);

    repeat (3) @(negedge clk);
    #1 run = 0;
    finish_run();
  end
endmodule